// File: doc/BRIEF.md
# Bitmap-Directed Multi-Bank Value Assembler

This block stores cached values across a row of small, independent word banks, one bank per pipeline stage, and rebuilds a value on demand. A key lookup upstream delivers a hit flag, a slot index and a bank-select mask. Every bank uses that same slot index. Each bank whose mask bit is set is read there, and the words read are packed into one wide output value. The output also carries a byte length and a hit flag.

A management port stores a value. It supplies an index, a mask and up to one packed word per bank, and only the selected banks are written. Reads and writes use the same packing rule. A mask therefore names the banks a value occupies, and an index plus mask pair is enough to locate any stored value. This lets a handful of narrow memories hold values several words long.

The block accepts one lookup per cycle. Results leave after a fixed two-register pipeline.

Top module: `nca_value_assembler`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0, `out_hit` is 0, `out_len` is 0 and `out_value` is all zero.
- R2: A write with `wr_en`=1 stores words only in the banks whose `wr_mask` bit is set, all at `wr_index`. Words are taken from `wr_data` in packing order: the lowest-numbered selected bank receives `wr_data[255:224]`, the next selected bank receives `wr_data[223:192]`, and so on. Banks whose bit is clear keep their contents, and a mask of zero changes nothing.
- R3: On a hit, the word of the lowest-numbered selected bank appears in `out_value[255:224]` and each further selected bank follows in the next lower 32-bit field, in ascending bank order. All bits below the last placed word are zero. Every selected bank is read at the shared `lk_index`.
- R4: On a hit with a nonzero mask, `out_hit`=1 and `out_len` equals 4 times the number of set mask bits, in bytes.
- R5: A lookup with `lk_hit`=0, or with `lk_mask`=0, still produces `out_valid`=1, with `out_hit`=0, `out_len`=0 and `out_value`=0.
- R6: A lookup presented with `lk_valid`=1 at clock edge k produces its result on the outputs after edge k+1. Lookups may arrive on every cycle and their results leave in order, one per cycle. `out_valid` is 0 in any cycle with no lookup two edges earlier.
- R7: When a write and a lookup reach the same bank and index on the same edge, the lookup returns the data held before the write. A later lookup returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | Lookup result present this cycle |
| lk_hit | input | 1 | Key was found in the lookup table |
| lk_index | input | 6 | Slot index shared by all banks |
| lk_mask | input | 8 | Bank-select mask, bit b selects bank b |
| wr_en | input | 1 | Management write strobe |
| wr_index | input | 6 | Slot index for the write |
| wr_mask | input | 8 | Banks to write |
| wr_data | input | 256 | Packed words to store, first word in the top bits |
| out_valid | output | 1 | Assembled result present |
| out_hit | output | 1 | Result carries a value |
| out_len | output | 6 | Value length in bytes |
| out_value | output | 256 | Packed value, first word in the top bits |

## Verification
Each slot is first loaded with full-mask writes whose words encode slot, bank and generation, so any word arriving from the wrong bank or index is caught. All 256 write masks are then applied to one slot, each followed by a full read. This separates correct routing of packed words to banks from writes that leak into unselected banks. All 256 read masks are swept at a fixed slot to check ordering, zero fill and length. A back-to-back stream that mixes hits, misses and varied masks exposes latency, ordering and stale-state faults. A same-edge write and read tells old-data return apart from write-through.

// File: rtl/nca_pkg.sv
// Package: shared mask type and bit-counting helpers for the value assembler.
// Assumes bank counts never exceed the width of mask_word_t (32).
package nca_pkg;

    typedef logic [31:0] mask_word_t;

    // Number of set bits in a mask word.
    function automatic int count_set(input mask_word_t m);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) n++;
        end
        return n;
    endfunction

    // Number of set bits strictly below bit position pos.
    function automatic int rank_of(input mask_word_t m, input int pos);
        int n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < pos && m[i]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/nca_bank.sv
// Module: one value bank, a simple dual-port word memory with a registered read.
// Assumes a single write port and a single read port on the same clock; a read
// and write to one address on the same edge returns the previous contents.
module nca_bank #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Store the incoming word when this bank is selected.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Register the addressed word; nonblocking update yields old data on collision.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/nca_write_route.sv
// Module: steers packed write words to banks. Bank b takes the word whose
// position equals the count of selected banks below b (first word in the top bits).
// Assumes NUM_BANKS <= 32.
module nca_write_route #(
    parameter int NUM_BANKS = 8,
    parameter int WORD_W    = 32,
    localparam int VW       = NUM_BANKS * WORD_W
) (
    input  logic                 wr_en,
    input  logic [NUM_BANKS-1:0] wr_mask,
    input  logic [VW-1:0]        wr_data,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [VW-1:0]        bank_wdata
);
    import nca_pkg::*;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_route
        int rk;

        // Position of this bank among the selected banks.
        always_comb rk = rank_of(mask_word_t'(wr_mask), b);

        assign bank_we[b]                   = wr_en && wr_mask[b];
        assign bank_wdata[b*WORD_W +: WORD_W] = wr_data[(NUM_BANKS-1-rk)*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/nca_assemble.sv
// Module: output stage. Packs the read words of selected banks from the top
// down in ascending bank order, zero fills the rest and computes the length.
// Assumes s1_mask is already cleared for a lookup miss.
module nca_assemble #(
    parameter int NUM_BANKS = 8,
    parameter int WORD_W    = 32,
    localparam int VW       = NUM_BANKS * WORD_W,
    localparam int BYTES    = WORD_W / 8,
    localparam int LEN_W    = $clog2(NUM_BANKS * BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s1_valid,
    input  logic [NUM_BANKS-1:0] s1_mask,
    input  logic [VW-1:0]        rd_flat,
    output logic                 out_valid,
    output logic                 out_hit,
    output logic [LEN_W-1:0]     out_len,
    output logic [VW-1:0]        out_value
);
    import nca_pkg::*;

    logic [VW-1:0]    packed_val;
    logic [LEN_W-1:0] len_bytes;

    // Place each selected bank's word in the next free field from the top.
    always_comb begin
        int slot;
        slot       = 0;
        packed_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (s1_mask[b]) begin
                packed_val[(NUM_BANKS-1-slot)*WORD_W +: WORD_W] = rd_flat[b*WORD_W +: WORD_W];
                slot++;
            end
        end
    end

    // Byte length from the number of contributing banks.
    always_comb len_bytes = LEN_W'(count_set(mask_word_t'(s1_mask)) * BYTES);

    // Register the assembled result; reset clears the whole output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_len   <= '0;
            out_value <= '0;
        end else begin
            out_valid <= s1_valid;
            out_hit   <= s1_valid && (s1_mask != '0);
            out_len   <= s1_valid ? len_bytes : '0;
            out_value <= s1_valid ? packed_val : '0;
        end
    end

    // R5: a result without a hit carries nothing.
    p_miss_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_len == '0 && out_value == '0));

    // R4: a hit carries a nonzero length no larger than the full value.
    p_hit_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (out_len != '0 && int'(out_len) <= NUM_BANKS * BYTES));

    // R3: every bit below the reported length is zero.
    p_tail_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_value << (int'(out_len) * 8)) == '0));

endmodule

// File: rtl/nca_value_assembler.sv
// Module: top of the multi-bank value assembler. Holds one bank per stage,
// reads every bank at the shared lookup index, and rebuilds the value two
// register stages later. A management write stores packed words into the
// banks named by its mask. Assumes lookups and writes are on the same clock.
module nca_value_assembler #(
    parameter int NUM_BANKS = 8,
    parameter int DEPTH     = 64,
    parameter int WORD_W    = 32,
    localparam int AW       = $clog2(DEPTH),
    localparam int VW       = NUM_BANKS * WORD_W,
    localparam int LEN_W    = $clog2(NUM_BANKS * (WORD_W / 8) + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic                 lk_hit,
    input  logic [AW-1:0]        lk_index,
    input  logic [NUM_BANKS-1:0] lk_mask,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_index,
    input  logic [NUM_BANKS-1:0] wr_mask,
    input  logic [VW-1:0]        wr_data,
    output logic                 out_valid,
    output logic                 out_hit,
    output logic [LEN_W-1:0]     out_len,
    output logic [VW-1:0]        out_value
);

    logic                 s1_valid;
    logic [NUM_BANKS-1:0] s1_mask;
    logic [NUM_BANKS-1:0] bank_we;
    logic [VW-1:0]        bank_wdata;
    logic [VW-1:0]        rd_flat;

    // Stage one: hold the lookup's validity and its effective mask (cleared on miss).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mask  <= '0;
        end else begin
            s1_valid <= lk_valid;
            s1_mask  <= (lk_valid && lk_hit) ? lk_mask : '0;
        end
    end

    nca_write_route #(
        .NUM_BANKS (NUM_BANKS),
        .WORD_W    (WORD_W)
    ) u_route (
        .wr_en      (wr_en),
        .wr_mask    (wr_mask),
        .wr_data    (wr_data),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        nca_bank #(
            .DEPTH  (DEPTH),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (wr_index),
            .wdata (bank_wdata[b*WORD_W +: WORD_W]),
            .raddr (lk_index),
            .rdata (rd_flat[b*WORD_W +: WORD_W])
        );
    end

    nca_assemble #(
        .NUM_BANKS (NUM_BANKS),
        .WORD_W    (WORD_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_mask   (s1_mask),
        .rd_flat   (rd_flat),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_len   (out_len),
        .out_value (out_value)
    );

    // R6: every result traces back to a lookup two edges earlier.
    p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(lk_valid, 2));

    // R5: a reported hit requires a hit from the lookup two edges earlier.
    p_hit_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> ($past(lk_hit, 2) && $past(lk_mask, 2) != '0));

endmodule

// File: tb/sim_nca_value_assembler.sv
`timescale 1ns/1ps
module sim_nca_value_assembler;
    localparam int NB = 8;
    localparam int DP = 64;
    localparam int W  = 32;
    localparam int VW = NB * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lk_valid, lk_hit;
    logic [5:0]    lk_index;
    logic [NB-1:0] lk_mask;
    logic          wr_en;
    logic [5:0]    wr_index;
    logic [NB-1:0] wr_mask;
    logic [VW-1:0] wr_data;
    logic          out_valid, out_hit;
    logic [5:0]    out_len;
    logic [VW-1:0] out_value;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] mdl [NB][DP];

    always #10 clk = ~clk;

    nca_value_assembler u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_index(lk_index), .lk_mask(lk_mask),
        .wr_en(wr_en), .wr_index(wr_index), .wr_mask(wr_mask), .wr_data(wr_data),
        .out_valid(out_valid), .out_hit(out_hit), .out_len(out_len), .out_value(out_value)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int idx, input int b, input int gen);
        return {8'(gen), 8'(idx), 8'(b), 8'(gen) ^ 8'h5A};
    endfunction

    function automatic logic [VW-1:0] exp_val(input int idx, input logic [NB-1:0] m, input bit hit);
        logic [VW-1:0] v;
        int s;
        v = '0;
        s = 0;
        if (hit) begin
            for (int b = 0; b < NB; b++) begin
                if (m[b]) begin
                    v[(NB-1-s)*W +: W] = mdl[b][idx];
                    s++;
                end
            end
        end
        return v;
    endfunction

    function automatic int exp_len(input logic [NB-1:0] m, input bit hit);
        int n;
        n = 0;
        for (int b = 0; b < NB; b++) if (m[b]) n++;
        return hit ? n * 4 : 0;
    endfunction

    task automatic check_out(input string req, input logic [VW-1:0] ev, input int el);
        chk(out_valid == 1'b1, {req, " valid"}, VW'(out_valid), VW'(1));
        chk(out_hit == (el != 0), {req, " hit"}, VW'(out_hit), VW'(el != 0));
        chk(int'(out_len) == el, {req, " len"}, VW'(out_len), VW'(el));
        chk(out_value == ev, {req, " value"}, out_value, ev);
    endtask

    task automatic do_write(input int idx, input logic [NB-1:0] m, input int gen);
        logic [VW-1:0] d;
        int s;
        for (int k = 0; k < NB; k++) d[(NB-1-k)*W +: W] = 32'hDEAD0000 | k;
        s = 0;
        for (int b = 0; b < NB; b++) begin
            if (m[b]) begin
                d[(NB-1-s)*W +: W] = pat(idx, b, gen);
                s++;
            end
        end
        @(negedge clk);
        wr_en = 1'b1; wr_index = 6'(idx); wr_mask = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int b = 0; b < NB; b++) if (m[b]) mdl[b][idx] = pat(idx, b, gen);
    endtask

    task automatic do_read(input int idx, input logic [NB-1:0] m, input bit hit, input string req);
        logic [VW-1:0] ev;
        int el;
        ev = exp_val(idx, m, hit);
        el = exp_len(m, hit);
        @(negedge clk);
        lk_valid = 1'b1; lk_hit = hit; lk_index = 6'(idx); lk_mask = m;
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        check_out(req, ev, el);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] sv [32];
        int            sl [32];
        logic [VW-1:0] old_v;

        rst_n = 1'b0; lk_valid = 1'b0; lk_hit = 1'b0; lk_index = '0; lk_mask = '0;
        wr_en = 1'b0; wr_index = '0; wr_mask = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        chk(out_valid == 1'b0 && out_hit == 1'b0 && out_len == '0 && out_value == '0,
            "R1 reset state", out_value, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 after reset", VW'(out_valid), '0);

        // Fill every slot, then read every slot with all banks (R2, R3 shared index)
        for (int i = 0; i < DP; i++) do_write(i, 8'hFF, 1);
        for (int i = 0; i < DP; i++) do_read(i, 8'hFF, 1'b1, "R3 full read per slot");

        // R2: every write mask at slot 7, then full read to expose leaks
        for (int m = 0; m < 256; m++) begin
            do_write(7, 8'(m), m + 2);
            do_read(7, 8'hFF, 1'b1, "R2 masked write");
        end

        // R3/R4: every read mask at slot 9
        for (int m = 1; m < 256; m++) do_read(9, 8'(m), 1'b1, "R3 R4 mask sweep");

        // R5: miss and empty mask
        do_read(11, 8'hFF, 1'b0, "R5 miss");
        do_read(11, 8'h00, 1'b1, "R5 empty mask");

        // R6: back-to-back stream, results one per cycle in order
        for (int j = 0; j < 34; j++) begin
            @(negedge clk);
            if (j >= 2) check_out("R6 stream", sv[j-2], sl[j-2]);
            else chk(out_valid == 1'b0, "R6 idle", VW'(out_valid), '0);
            if (j < 32) begin
                logic [NB-1:0] m;
                bit h;
                m = 8'((j * 37 + 1) & 255);
                h = (j % 5) != 0;
                sv[j] = exp_val(j, m, h);
                sl[j] = exp_len(m, h);
                lk_valid = 1'b1; lk_hit = h; lk_index = 6'(j); lk_mask = m;
            end else begin
                lk_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 drained", VW'(out_valid), '0);

        // R7: same-edge write and read at slot 3 returns old data
        old_v = exp_val(3, 8'hFF, 1'b1);
        @(negedge clk);
        wr_en = 1'b1; wr_index = 6'd3; wr_mask = 8'hFF;
        for (int b = 0; b < NB; b++) wr_data[(NB-1-b)*W +: W] = pat(3, b, 200);
        lk_valid = 1'b1; lk_hit = 1'b1; lk_index = 6'd3; lk_mask = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        for (int b = 0; b < NB; b++) mdl[b][3] = pat(3, b, 200);
        @(negedge clk);
        check_out("R7 old data on collision", old_v, 32);
        do_read(3, 8'hFF, 1'b1, "R7 new data afterwards");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule